// File: doc/BRIEF.md
# Frame-Indexed Associative Address Translator

This block is a single system-wide translation table. It holds one slot for each physical frame, so its size follows physical memory and not the virtual address space. Each slot holds the owner's process identifier, a virtual page number and a residency bit. Slots from every process share the same table.

A lookup presents a process identifier and a virtual address. The virtual page number is compared against every slot at once. The position of the one matching resident slot is the physical frame number. That frame number is placed above the untouched page offset to form the physical address, which is returned one cycle later. When no resident slot matches, a fault flag is raised.

A single write port lets operating-system software do two things:
- install a mapping into a chosen frame;
- drop the residency of a chosen frame.

The write port keeps tags unique. Installing a tag that already lives in another frame clears that other frame's residency at the same edge.

Top module: `ipt_lookup`

## Requirements
- R1: After synchronous reset, `rsp_valid` is low and every slot is non-resident, so any lookup faults.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R3: A lookup that matches a resident slot at index f returns `rsp_fault` = 0 and `rsp_paddr` = {f, offset}. The frame occupies bits [PA_W-1:OFF_W]; the offset is `req_vaddr[OFF_W-1:0]` copied unchanged.
- R4: A match needs both fields of the tag to be equal. The same page number under a different process identifier misses.
- R5: A lookup with no resident match returns `rsp_fault` = 1 and `rsp_paddr` = 0.
- R6: With `wr_en` high and `wr_op` = 1 (install), slot `wr_frame` takes the new {`wr_pid`, `wr_vpn`} tag and becomes resident; the tag it held before no longer hits.
- R7: With `wr_en` high and `wr_op` = 0 (drop), only slot `wr_frame` loses residency; other slots keep translating.
- R8: An install whose tag equals a resident slot elsewhere clears that other slot at the same edge, so at most one resident slot ever matches a lookup.
- R9: A lookup and a write at the same edge compare against the table as it was before that write.
- R10: The virtual page number is `req_vaddr[VA_W-1:OFF_W]`, where VA_W = VPN_W + OFF_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_pid | input | PID_W | Requesting process identifier |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| wr_en | input | 1 | Table write strobe |
| wr_op | input | 1 | 1 = install mapping, 0 = drop residency |
| wr_frame | input | $clog2(FRAMES) | Frame slot to write |
| wr_pid | input | PID_W | Process identifier to install |
| wr_vpn | input | VPN_W | Virtual page number to install |
| rsp_valid | output | 1 | Lookup result strobe |
| rsp_fault | output | 1 | No resident mapping found |
| rsp_paddr | output | $clog2(FRAMES)+OFF_W | Translated physical address |

## Verification
The bench builds the block with its defaults: eight frames, a 3-bit process identifier, a 5-bit page number and a 4-bit offset. With eight frames, the highest frame index, 7, can be placed in the top address bits. The widths are also small enough to pick page numbers and identifiers by hand that collide in one field but not the other. A narrow offset lets the bench walk both the all-zero and the all-one offsets and confirm they pass through unchanged. It also leaves room to move a tag between two frames and then prove the old frame was cleared.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int unsigned DEF_FRAMES = 8;
    localparam int unsigned DEF_PID_W  = 3;
    localparam int unsigned DEF_VPN_W  = 5;
    localparam int unsigned DEF_OFF_W  = 4;

    typedef enum logic {
        WR_DROP = 1'b0,
        WR_FILL = 1'b1
    } wr_op_e;

    // true when bit b of slot number i is set
    function automatic logic slot_bit(input int unsigned i, input int unsigned b);
        return ((i >> b) & 1) == 1;
    endfunction

endpackage

// File: rtl/ipt_entry.sv
module ipt_entry #(
    parameter int unsigned PID_W = 3,
    parameter int unsigned VPN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_sel,
    input  logic             drop_sel,
    input  logic             fill_any,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PID_W-1:0] lk_pid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit
);

    logic             res_q;
    logic [PID_W-1:0] pid_q;
    logic [VPN_W-1:0] vpn_q;
    logic             dup_here;

    assign dup_here = res_q && (pid_q == wr_pid) && (vpn_q == wr_vpn);
    assign hit      = res_q && (pid_q == lk_pid) && (vpn_q == lk_vpn);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= 1'b0;
            pid_q <= '0;
            vpn_q <= '0;
        end else if (fill_sel) begin
            res_q <= 1'b1;
            pid_q <= wr_pid;
            vpn_q <= wr_vpn;
        end else if (drop_sel) begin
            res_q <= 1'b0;
        end else if (fill_any && dup_here) begin
            res_q <= 1'b0;
        end
    end

    // R6
    fill_sets_res_chk: assert property (@(posedge clk) disable iff (rst)
        fill_sel |=> (res_q && pid_q == $past(wr_pid) && vpn_q == $past(wr_vpn)));

    // R7
    drop_clears_res_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_sel && !fill_sel) |=> !res_q);

    // R8
    dup_evicted_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_any && !fill_sel && dup_here) |=> !res_q);

endmodule

// File: rtl/ipt_encoder.sv
module ipt_encoder #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] hits,
    output logic [W-1:0] idx,
    output logic         any
);
    import ipt_pkg::*;

    assign any = |hits;

    // With a one-hot input, each index bit is the OR of the slots that have that bit set.
    always_comb begin
        idx = '0;
        for (int unsigned b = 0; b < W; b++) begin
            for (int unsigned i = 0; i < N; i++) begin
                if (slot_bit(i, b) && hits[i]) idx[b] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int unsigned FRAMES = ipt_pkg::DEF_FRAMES,
    parameter int unsigned PID_W  = ipt_pkg::DEF_PID_W,
    parameter int unsigned VPN_W  = ipt_pkg::DEF_VPN_W,
    parameter int unsigned OFF_W  = ipt_pkg::DEF_OFF_W,
    localparam int unsigned FRAME_W = $clog2(FRAMES),
    localparam int unsigned VA_W    = VPN_W + OFF_W,
    localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [PID_W-1:0]   req_pid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               wr_en,
    input  logic               wr_op,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [VPN_W-1:0]   wr_vpn,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr
);
    import ipt_pkg::*;

    wr_op_e             op;
    logic               fill_any;
    logic               drop_any;
    logic [VPN_W-1:0]   lk_vpn;
    logic [OFF_W-1:0]   lk_off;
    logic [FRAMES-1:0]  hits;
    logic [FRAME_W-1:0] hit_idx;
    logic               hit_any;

    assign op       = wr_op_e'(wr_op);
    assign fill_any = wr_en && (op == WR_FILL);
    assign drop_any = wr_en && (op == WR_DROP);
    assign lk_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign lk_off   = req_vaddr[OFF_W-1:0];

    for (genvar f = 0; f < FRAMES; f++) begin : g_slot
        logic sel;
        assign sel = (wr_frame == FRAME_W'(f));
        ipt_entry #(.PID_W(PID_W), .VPN_W(VPN_W)) u_ent (
            .clk      (clk),
            .rst      (rst),
            .fill_sel (fill_any && sel),
            .drop_sel (drop_any && sel),
            .fill_any (fill_any),
            .wr_pid   (wr_pid),
            .wr_vpn   (wr_vpn),
            .lk_pid   (req_pid),
            .lk_vpn   (lk_vpn),
            .hit      (hits[f])
        );
    end

    ipt_encoder #(.N(FRAMES), .W(FRAME_W)) u_enc (
        .hits (hits),
        .idx  (hit_idx),
        .any  (hit_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= !hit_any;
                rsp_paddr <= hit_any ? {hit_idx, lk_off} : '0;
            end
        end
    end

    // R8
    unique_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R5
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_any) |=> (!rsp_fault && rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

endmodule

// File: tb/sim_ipt_lookup.sv
module sim_ipt_lookup;

    localparam int FW = 3, PW = 3, VW = 5, OW = 4;
    localparam int AW = VW + OW, QW = FW + OW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [PW-1:0] req_pid;
    logic [AW-1:0] req_vaddr;
    logic          wr_en;
    logic          wr_op;
    logic [FW-1:0] wr_frame;
    logic [PW-1:0] wr_pid;
    logic [VW-1:0] wr_vpn;
    logic          rsp_valid;
    logic          rsp_fault;
    logic [QW-1:0] rsp_paddr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ipt_lookup u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_pid(req_pid), .req_vaddr(req_vaddr),
        .wr_en(wr_en), .wr_op(wr_op), .wr_frame(wr_frame), .wr_pid(wr_pid), .wr_vpn(wr_vpn),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    typedef struct packed {
        logic [PW-1:0] pid;
        logic [AW-1:0] va;
        logic          f;
        logic [QW-1:0] pa;
    } vec_t;

    // lookups against the table: f0=(1,3) f5=(2,3) f7=(1,31) f2=(0,0)
    localparam vec_t VECS [8] = '{
        '{pid:3'd1, va:9'h03A, f:1'b0, pa:7'h0A},  // R3 R10
        '{pid:3'd2, va:9'h035, f:1'b0, pa:7'h55},  // R3
        '{pid:3'd1, va:9'h1FF, f:1'b0, pa:7'h7F},  // R3 top frame, all-one offset
        '{pid:3'd0, va:9'h000, f:1'b0, pa:7'h20},  // R3 all-zero offset
        '{pid:3'd3, va:9'h033, f:1'b1, pa:7'h00},  // R4
        '{pid:3'd1, va:9'h040, f:1'b1, pa:7'h00},  // R5
        '{pid:3'd2, va:9'h1F0, f:1'b1, pa:7'h00},  // R4
        '{pid:3'd0, va:9'h00C, f:1'b0, pa:7'h2C}   // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [PW-1:0] pid, input logic [AW-1:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_pid = pid; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write(input logic op, input logic [FW-1:0] fr,
                         input logic [PW-1:0] pid, input logic [VW-1:0] vpn);
        @(negedge clk);
        wr_en = 1'b1; wr_op = op; wr_frame = fr; wr_pid = pid; wr_vpn = vpn;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic f, input logic [QW-1:0] pa);
        chk(req, {31'd0, rsp_valid}, 32'd1);
        chk(req, {31'd0, rsp_fault}, {31'd0, f});
        chk(req, {25'd0, rsp_paddr}, {25'd0, pa});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_pid = '0; req_vaddr = '0;
        wr_en = 1'b0; wr_op = 1'b0; wr_frame = '0; wr_pid = '0; wr_vpn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
        lookup(3'd1, 9'h03A);
        expect_rsp("R1", 1'b1, 7'h00);
        // R2 strobe drops one cycle later
        @(negedge clk);
        chk("R2", {31'd0, rsp_valid}, 32'd0);

        write(1'b1, 3'd0, 3'd1, 5'd3);
        write(1'b1, 3'd5, 3'd2, 5'd3);
        write(1'b1, 3'd7, 3'd1, 5'd31);
        write(1'b1, 3'd2, 3'd0, 5'd0);

        foreach (VECS[i]) begin
            lookup(VECS[i].pid, VECS[i].va);
            expect_rsp($sformatf("R3/R4/R5/R10 vec%0d", i), VECS[i].f, VECS[i].pa);
        end

        // R6 overwrite frame 0
        write(1'b1, 3'd0, 3'd4, 5'd9);
        lookup(3'd1, 9'h03A);
        expect_rsp("R6 old tag", 1'b1, 7'h00);
        lookup(3'd4, 9'h091);
        expect_rsp("R6 new tag", 1'b0, 7'h01);

        // R7 drop frame 5 only
        write(1'b0, 3'd5, 3'd0, 5'd0);
        lookup(3'd2, 9'h035);
        expect_rsp("R7 dropped", 1'b1, 7'h00);
        lookup(3'd1, 9'h1FF);
        expect_rsp("R7 neighbour", 1'b0, 7'h7F);

        // R8 move tag (1,31) from frame 7 to frame 3
        write(1'b1, 3'd3, 3'd1, 5'd31);
        lookup(3'd1, 9'h1F6);
        expect_rsp("R8 moved", 1'b0, 7'h36);
        write(1'b0, 3'd3, 3'd0, 5'd0);
        lookup(3'd1, 9'h1F6);
        expect_rsp("R8 old cleared", 1'b1, 7'h00);

        // R9 lookup at the same edge as the install sees the old table
        @(negedge clk);
        wr_en = 1'b1; wr_op = 1'b1; wr_frame = 3'd6; wr_pid = 3'd5; wr_vpn = 5'd7;
        req_valid = 1'b1; req_pid = 3'd5; req_vaddr = 9'h070;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R9 same edge", 1'b1, 7'h00);
        lookup(3'd5, 9'h070);
        expect_rsp("R9 after", 1'b0, 7'h60);

        // R1 reset clears every slot
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        lookup(3'd5, 9'h070);
        expect_rsp("R1 after reset", 1'b1, 7'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule